// File: doc/BRIEF.md
# Protection Entry Configuration Register (Entries 8 to 15)

This block is the machine-mode control register that stores the 8-bit settings of a group of physical memory protection entries, numbered 8 through 15. Software reaches it through a simple register access port: an address, a write strobe, write data and combinational read data. A view input picks a 32-bit register (entries 8 to 11) or a 64-bit register (entries 8 to 15). Elaboration parameters set how many entries the core implements in total and the protection granularity.

Each byte of a write is judged on its own. A byte is either stored whole, with its two reserved bits cleared, or dropped, leaving the previous byte in place. A byte is dropped when the stored entry is locked, when it asks for the reserved write-without-read permission, or when it selects the four-byte aligned match mode on a core whose granularity rules that mode out. Entries at or above the implemented count are fixed at zero. The stored bytes and a per-entry lock flag are exported to the access checker that sits beside the register.

Top module: `pmpg_cfg_csr`

## Requirements
- R1: On a synchronous active-low reset every implemented entry byte becomes 0 (match mode off, unlocked), and every lock output is 0.
- R2: The register answers only at address 0x3a2 with `priv_m` high. Any other address, or `priv_m` low, leaves all bytes unchanged on a write and gives read data 0.
- R3: With `wide_view` high, entry 8+k occupies data bits [8k+7:8k] for k = 0..7. With `wide_view` low, only entries 8 to 11 (bits 31:0) take part. Bits 63:32 read as 0 and their write bytes are ignored.
- R4: Inside an entry byte, bit 7 is lock, bits 6:5 are reserved, bits 4:3 are the match mode (0 off, 1 top-of-range, 2 four-byte aligned, 3 power-of-two aligned), bit 2 is execute, bit 1 is write and bit 0 is read. Reserved bits are always stored as 0.
- R5: When an entry's stored lock bit is 1, writes to that entry's byte are ignored.
- R6: A written byte with read = 0 and write = 1 is rejected, and the entry keeps its old byte.
- R7: With `GRAIN` of 2 or more, a written byte with match mode 2 is rejected and the entry keeps its old byte. With `GRAIN` below 2, that mode is stored.
- R8: An entry whose index is not below `ENTRY_COUNT` always reads 0 and reports lock 0.
- R9: Acceptance is decided per entry byte, so a rejected byte never stops other bytes of the same write from updating.
- R10: `cfg_out` carries every stored entry byte in the same layout as the read data. `lock_out[k]` is the lock bit of entry 8+k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_addr | input | 12 | Register address |
| csr_we | input | 1 | Write strobe |
| csr_wdata | input | 64 | Write data, one byte per entry |
| priv_m | input | 1 | High when the access is made in machine mode |
| wide_view | input | 1 | 1 selects the 64-bit view, 0 the 32-bit view |
| csr_rdata | output | 64 | Combinational read data |
| cfg_out | output | 64 | Stored entry bytes for the access checker |
| lock_out | output | 8 | Per-entry lock flags |

## Verification
The bench builds two copies side by side and drives both with the same access stream. The first copy has `ENTRY_COUNT` = 12 and `GRAIN` = 2, so it covers the four-byte-mode ban and the zeroed entries 12 to 15. The second copy has `ENTRY_COUNT` = 16 and `GRAIN` = 0, so every upper byte holds real state. In that copy the four-byte mode must be stored, and the 32-bit view must leave the upper entries untouched, which the first copy cannot show.

// File: rtl/pmpg_pkg.sv
// Package: shared field positions, types and masks for the entry
// configuration register. Assumes 8-bit entry bytes.
package pmpg_pkg;

    localparam int CFG_W    = 8;
    localparam int BIT_R    = 0;
    localparam int BIT_W    = 1;
    localparam int BIT_X    = 2;
    localparam int MODE_LO  = 3;
    localparam int MODE_HI  = 4;
    localparam int BIT_LOCK = 7;

    // Bits kept when storing a byte: everything except reserved 6:5
    localparam logic [CFG_W-1:0] KEEP_MASK = 8'h9F;

    typedef logic [CFG_W-1:0] cfg_byte_t;

    typedef enum logic [1:0] {
        MATCH_OFF   = 2'd0,
        MATCH_TOR   = 2'd1,
        MATCH_NA4   = 2'd2,
        MATCH_NAPOT = 2'd3
    } match_mode_e;

endpackage

// File: rtl/pmpg_legalize.sv
// Module: pmpg_legalize
// Decides whether one proposed entry byte may replace the stored one,
// and produces the byte to store with its reserved bits cleared.
// Assumes: pure combinational, judged per entry with no cross-entry terms.
module pmpg_legalize
    import pmpg_pkg::*;
#(
    parameter int GRAIN = 0
) (
    input  cfg_byte_t old_cfg,
    input  cfg_byte_t new_cfg,
    output logic      accept,
    output cfg_byte_t clean_cfg
);

    logic locked;
    logic rw_reserved;
    logic mode_banned;

    assign locked      = old_cfg[BIT_LOCK];
    assign rw_reserved = new_cfg[BIT_W] & ~new_cfg[BIT_R];

    // Granularity picks whether the four-byte aligned mode is allowed
    generate
        if (GRAIN >= 2) begin : g_coarse
            assign mode_banned = (match_mode_e'(new_cfg[MODE_HI:MODE_LO]) == MATCH_NA4);
        end else begin : g_fine
            assign mode_banned = 1'b0;
        end
    endgenerate

    // Acceptance: unlocked, no reserved permission pair, mode allowed
    always_comb begin
        accept    = ~locked & ~rw_reserved & ~mode_banned;
        clean_cfg = new_cfg & KEEP_MASK;
    end

endmodule

// File: rtl/pmpg_slot.sv
// Module: pmpg_slot
// Storage for one implemented entry byte. A write takes effect only when
// the legalizer accepts the proposed byte; otherwise the old byte stays.
// Assumes: synchronous active-low reset clears the entry to off/unlocked.
module pmpg_slot
    import pmpg_pkg::*;
#(
    parameter int GRAIN = 0
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  cfg_byte_t wr_byte,
    output cfg_byte_t cfg_q
);

    logic      accept;
    cfg_byte_t clean_cfg;

    pmpg_legalize #(.GRAIN(GRAIN)) i_legal (
        .old_cfg  (cfg_q),
        .new_cfg  (wr_byte),
        .accept   (accept),
        .clean_cfg(clean_cfg)
    );

    // Entry register: reset to zero, load only legal bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en && accept) begin
            cfg_q <= clean_cfg;
        end
    end

    // R5
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[BIT_LOCK] |=> $stable(cfg_q));

    // R6
    no_rw_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_q[BIT_W] && !cfg_q[BIT_R]));

    // R4
    rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[6:5] == 2'b00);

    generate
        if (GRAIN >= 2) begin : g_mode_chk
            // R7
            no_na4_chk: assert property (@(posedge clk) disable iff (!rst_n)
                cfg_q[MODE_HI:MODE_LO] != MATCH_NA4);
        end
    endgenerate

endmodule

// File: rtl/pmpg_cfg_csr.sv
// Module: pmpg_cfg_csr
// Machine-mode register holding the configuration bytes of entries
// FIRST_ENTRY..FIRST_ENTRY+SLOTS-1. Decodes the address and privilege,
// applies the 32/64-bit view, and stores each byte through its own slot.
// Assumes: entries at or above ENTRY_COUNT are absent and read as zero.
module pmpg_cfg_csr
    import pmpg_pkg::*;
#(
    parameter logic [11:0] CSR_ADDR    = 12'h3A2,
    parameter int          FIRST_ENTRY = 8,
    parameter int          SLOTS       = 8,
    parameter int          ENTRY_COUNT = 16,
    parameter int          GRAIN       = 0,
    localparam int         DATA_W      = SLOTS * CFG_W,
    localparam int         NARROW_N    = SLOTS / 2,
    localparam int         NARROW_W    = NARROW_N * CFG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [11:0]       csr_addr,
    input  logic              csr_we,
    input  logic [DATA_W-1:0] csr_wdata,
    input  logic              priv_m,
    input  logic              wide_view,
    output logic [DATA_W-1:0] csr_rdata,
    output logic [DATA_W-1:0] cfg_out,
    output logic [SLOTS-1:0]  lock_out
);

    logic      rd_sel;
    logic      wr_hit;
    cfg_byte_t slot_cfg [SLOTS];

    // Access decode: matching address in machine mode
    always_comb begin
        rd_sel = priv_m && (csr_addr == CSR_ADDR);
        wr_hit = rd_sel && csr_we;
    end

    generate
        for (genvar k = 0; k < SLOTS; k++) begin : g_slot
            localparam bit IN_NARROW = (k < NARROW_N);
            logic view_on;
            assign view_on = wide_view || IN_NARROW;

            if (FIRST_ENTRY + k < ENTRY_COUNT) begin : g_impl
                pmpg_slot #(.GRAIN(GRAIN)) i_slot (
                    .clk    (clk),
                    .rst_n  (rst_n),
                    .wr_en  (wr_hit && view_on),
                    .wr_byte(csr_wdata[k*CFG_W +: CFG_W]),
                    .cfg_q  (slot_cfg[k])
                );
            end else begin : g_absent
                assign slot_cfg[k] = '0;
            end

            assign cfg_out[k*CFG_W +: CFG_W]   = slot_cfg[k];
            assign lock_out[k]                 = slot_cfg[k][BIT_LOCK];
            assign csr_rdata[k*CFG_W +: CFG_W] = (rd_sel && view_on) ? slot_cfg[k] : '0;
        end
    endgenerate

    // R2
    miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(cfg_out));

    // R3
    narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_view |=> $stable(cfg_out[DATA_W-1:NARROW_W]));

endmodule

// File: tb/test_pmpg_cfg_csr.sv
// Scoreboard bench: the driver pushes expected read results into a queue,
// the monitor pops and compares them on each read cycle. Two copies run
// in parallel: A (12 entries, granularity 2) and B (16 entries, granularity 0).
module test_pmpg_cfg_csr;

    typedef struct {
        logic [63:0] exp_a;
        logic [63:0] exp_b;
        logic [7:0]  lock_a;
        logic [7:0]  lock_b;
        string       req;
    } exp_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] csr_addr = 12'h3A2;
    logic        csr_we = 1'b0;
    logic [63:0] csr_wdata = '0;
    logic        priv_m = 1'b1;
    logic        wide_view = 1'b1;
    logic        rd_valid = 1'b0;
    logic [63:0] rdata_a, rdata_b, cfg_a, cfg_b;
    logic [7:0]  lock_a, lock_b;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    exp_item_t sb_q[$];

    always #5 clk = ~clk;

    pmpg_cfg_csr #(.ENTRY_COUNT(12), .GRAIN(2)) i_pmpg_cfg_csr (
        .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_we(csr_we),
        .csr_wdata(csr_wdata), .priv_m(priv_m), .wide_view(wide_view),
        .csr_rdata(rdata_a), .cfg_out(cfg_a), .lock_out(lock_a)
    );

    pmpg_cfg_csr #(.ENTRY_COUNT(16), .GRAIN(0)) i_pmpg_cfg_csr_g0 (
        .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_we(csr_we),
        .csr_wdata(csr_wdata), .priv_m(priv_m), .wide_view(wide_view),
        .csr_rdata(rdata_b), .cfg_out(cfg_b), .lock_out(lock_b)
    );

    task automatic check64(input string req, input string what,
                           input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] addr, input logic [63:0] data);
        @(negedge clk);
        csr_addr  = addr;
        csr_wdata = data;
        csr_we    = 1'b1;
        @(negedge clk);
        csr_we    = 1'b0;
    endtask

    task automatic rd(input logic [11:0] addr, input logic [63:0] ea,
                      input logic [63:0] eb, input logic [7:0] la,
                      input logic [7:0] lb, input string req);
        exp_item_t it;
        it.exp_a = ea; it.exp_b = eb; it.lock_a = la; it.lock_b = lb; it.req = req;
        @(negedge clk);
        csr_addr = addr;
        rd_valid = 1'b1;
        sb_q.push_back(it);
        @(negedge clk);
        rd_valid = 1'b0;
    endtask

    // Monitor: compare read data and lock outputs mid-cycle
    always begin
        @(posedge clk);
        if (rd_valid) begin
            #3;
            if (sb_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL scoreboard: read with empty queue, actual 1 expected 0");
            end else begin
                exp_item_t it;
                it = sb_q.pop_front();
                check64(it.req, "rdata A", rdata_a, it.exp_a);
                check64(it.req, "rdata B", rdata_b, it.exp_b);
                check64(it.req, "lock A", {56'd0, lock_a}, {56'd0, it.lock_a});
                check64(it.req, "lock B", {56'd0, lock_b}, {56'd0, it.lock_b});
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 R8: reset state
        rd(12'h3A2, 64'h0, 64'h0, 8'h00, 8'h00, "R1 R8 reset");
        // R4 R6 R8: reserved bits dropped, W-without-R rejected, absent entries zero
        wr(12'h3A2, 64'h1F1F_1F1F_6102_1B0F);
        rd(12'h3A2, 64'h0000_0000_0100_1B0F, 64'h1F1F_1F1F_0100_1B0F,
           8'h00, 8'h00, "R4 R6 R8 layout");
        // R7 R9: four-byte mode banned in A only, other bytes still update
        wr(12'h3A2, 64'h1F1F_1F1F_0513_1B11);
        rd(12'h3A2, 64'h0000_0000_0500_1B0F, 64'h1F1F_1F1F_0513_1B11,
           8'h00, 8'h00, "R7 R9 per-byte");
        // R10: locking entry 9 shows on lock_out bit 1
        wr(12'h3A2, 64'h1F1F_1F1F_0500_990F);
        rd(12'h3A2, 64'h0000_0000_0500_990F, 64'h1F1F_1F1F_0500_990F,
           8'h02, 8'h02, "R10 lock out");
        check64("R10", "cfg_out B", cfg_b, 64'h1F1F_1F1F_0500_990F);
        // R5: locked entry 9 ignores the write, entry 8 updates
        wr(12'h3A2, 64'h1F1F_1F1F_0500_0000);
        rd(12'h3A2, 64'h0000_0000_0500_9900, 64'h1F1F_1F1F_0500_9900,
           8'h02, 8'h02, "R5 locked");
        // R3: narrow view writes and reads low half only
        wide_view = 1'b0;
        wr(12'h3A2, 64'h0000_0000_0700_0003);
        rd(12'h3A2, 64'h0000_0000_0700_9903, 64'h0000_0000_0700_9903,
           8'h02, 8'h02, "R3 narrow read");
        wide_view = 1'b1;
        rd(12'h3A2, 64'h0000_0000_0700_9903, 64'h1F1F_1F1F_0700_9903,
           8'h02, 8'h02, "R3 upper kept");
        // R2: other address
        wr(12'h3A0, 64'h0);
        rd(12'h3A0, 64'h0, 64'h0, 8'h02, 8'h02, "R2 other addr read");
        rd(12'h3A2, 64'h0000_0000_0700_9903, 64'h1F1F_1F1F_0700_9903,
           8'h02, 8'h02, "R2 other addr write");
        // R2: not machine mode
        priv_m = 1'b0;
        wr(12'h3A2, 64'h0);
        rd(12'h3A2, 64'h0, 64'h0, 8'h02, 8'h02, "R2 non-machine read");
        priv_m = 1'b1;
        rd(12'h3A2, 64'h0000_0000_0700_9903, 64'h1F1F_1F1F_0700_9903,
           8'h02, 8'h02, "R2 non-machine write");
        // R1: reset clears even a locked entry
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(12'h3A2, 64'h0, 64'h0, 8'h00, 8'h00, "R1 re-reset");
        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #2000000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run hung, actual timeout expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule